// File: doc/BRIEF.md
# DDR SDRAM Command Decoder and Bank State Tracker

This block sits beside the command pins of a four-bank double-data-rate SDRAM-style device. On every rising clock edge it samples chip select, the three command strobes, the clock-enable, the bank address and the 12-bit address bus, and turns them into a compact command code. It also keeps a model of each bank: whether the bank is idle or has a row open, and which row that is.

Address bit 10 does two jobs. On a read or write it asks for the bank to be closed automatically once the burst is over. On a precharge it widens the close to every bank. The burst length is given to the block in clock cycles on a small input, and an auto-closing bank drops out of the active set that many cycles after its command. Commands that do not fit the current bank state raise a one-cycle illegal flag and leave the bank model untouched. Data transfer and timing limits between commands are not handled here.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: With `cs_n` high the command code is DESEL (0), `illegal` stays low and no bank state changes, whatever the strobes carry.
- R2: With `cs_n` low, strobes {ras_n,cas_n,we_n}=111 give NOP (1). The combinations 000 and 110 give OTHER (10). Neither changes bank state.
- R3: Strobes 011 give ACT (2). When the addressed bank is idle, it becomes active and its open row becomes the full 12-bit address.
- R4: Strobes 101 with address bit 10 low give RD (3), and 100 with bit 10 low give WR (5). On an active, non-closing bank they leave all bank state as it is.
- R5: With address bit 10 high, 101 gives RDA (4) and 100 gives WRA (6). A legal one closes the bank `ap_len` edges after the command edge, with an `ap_len` of 0 treated as 1.
- R6: Strobes 010 with bit 10 low give PRE (7). It closes the addressed bank at once and cancels any pending automatic close on it. A PRE to an idle bank is legal and has no effect.
- R7: Strobes 010 with bit 10 high give PREA (8). It closes every bank and cancels every pending close.
- R8: Strobes 001 give REF (9) when `cke` is high and OTHER (10) when `cke` is low. A legal REF finds all banks idle and leaves them idle.
- R9: `illegal` is high for one cycle, and the commanded change is not made, in these cases: an ACT to an active bank, any read or write to an idle bank or to a bank with a pending automatic close, and a REF while any bank is active.
- R10: `all_idle` is high exactly when no bit of `bank_active` is set.
- R11: `cmd_code`, `cmd_bank` and `illegal` show the command sampled at the most recent edge. Bank state changes at that same edge. After reset every output is 0, except `all_idle`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable, qualifies refresh |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Row / column address, bit 10 is the close/all flag |
| ap_len | input | 4 | Burst length in cycles for automatic close |
| cmd_code | output | 4 | Decoded command of the last edge |
| cmd_bank | output | 2 | Bank address of the last edge |
| illegal | output | 1 | Last command conflicted with bank state |
| bank_active | output | 4 | Per-bank open flag |
| open_rows | output | 48 | Per-bank last opened row, bank i at bits 12*i+11..12*i |
| all_idle | output | 1 | No bank open |

## Verification
A wrong bank model does not stay hidden. An open flag that is wrongly set or cleared shows on `bank_active` and `all_idle` one cycle after the faulty edge. It then shows again through `illegal` on the next ACT, read or write aimed at that bank. A miscounted close timer moves the drop of the bank's active bit by one or more cycles, so comparing every output on every clock against a behavioural model places the fault at the exact edge. A wrong stored row is visible on `open_rows` as soon as the ACT has been registered.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;
   typedef enum logic [3:0] {
      CMD_DESEL = 4'd0,
      CMD_NOP   = 4'd1,
      CMD_ACT   = 4'd2,
      CMD_RD    = 4'd3,
      CMD_RDA   = 4'd4,
      CMD_WR    = 4'd5,
      CMD_WRA   = 4'd6,
      CMD_PRE   = 4'd7,
      CMD_PREA  = 4'd8,
      CMD_REF   = 4'd9,
      CMD_OTHER = 4'd10
   } cmd_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_cmd_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   input  logic flag_bit,
   output cmd_e cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b111:  cmd = CMD_NOP;
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = flag_bit ? CMD_RDA : CMD_RD;
            3'b100:  cmd = flag_bit ? CMD_WRA : CMD_WR;
            3'b010:  cmd = flag_bit ? CMD_PREA : CMD_PRE;
            3'b001:  cmd = cke ? CMD_REF : CMD_OTHER;
            default: cmd = CMD_OTHER;
         endcase
      end
   end
endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
   parameter int ROW_W = 12,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_go,
   input  logic             close_go,
   input  logic             arm_go,
   input  logic [CNT_W-1:0] arm_val,
   input  logic [ROW_W-1:0] row_in,
   output logic             active,
   output logic             pending,
   output logic [ROW_W-1:0] row
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         pending <= 1'b0;
         cnt     <= '0;
         row     <= '0;
      end else begin
         if (open_go) begin
            active <= 1'b1;
            row    <= row_in;
         end
         if (close_go) begin
            active  <= 1'b0;
            pending <= 1'b0;
         end else if (arm_go) begin
            pending <= 1'b1;
            cnt     <= arm_val;
         end else if (pending) begin
            if (cnt == '0) begin
               active  <= 1'b0;
               pending <= 1'b0;
            end else begin
               cnt <= cnt - 1'b1;
            end
         end
      end
   end

   // R3
   act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      open_go |=> active && row == $past(row_in));
   // R5
   ap_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && cnt == '0 && !close_go) |=> !active);
   // R6
   pre_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      close_go |=> !active && !pending);
   // R5
   pend_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pending |-> active);
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdram_cmd_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int FLAG_BIT  = 10,
   parameter int CNT_W     = 4,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cke,
   input  logic                       cs_n,
   input  logic                       ras_n,
   input  logic                       cas_n,
   input  logic                       we_n,
   input  logic [BA_W-1:0]            ba,
   input  logic [ADDR_W-1:0]          addr,
   input  logic [CNT_W-1:0]           ap_len,
   output logic [3:0]                 cmd_code,
   output logic [BA_W-1:0]            cmd_bank,
   output logic                       illegal,
   output logic [NUM_BANKS-1:0]       bank_active,
   output logic [NUM_BANKS*ADDR_W-1:0] open_rows,
   output logic                       all_idle
);
   if (FLAG_BIT >= ADDR_W) begin : g_bad_flag
      $error("FLAG_BIT must index into the address bus");
   end
   if ((1 << BA_W) != NUM_BANKS || NUM_BANKS < 2) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two, at least 2");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("CNT_W must be at least 1");
   end

   cmd_e                 cmd;
   logic [NUM_BANKS-1:0] sel, pend, open_go, close_go, arm_go;
   logic [CNT_W-1:0]     arm_val;
   logic                 is_act, is_rw, is_ap, is_ref, cur_act, cur_pend, bad;

   sdram_cmd_decode u_dec (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .cke(cke), .flag_bit(addr[FLAG_BIT]), .cmd(cmd)
   );

   assign is_act   = (cmd == CMD_ACT);
   assign is_ap    = (cmd == CMD_RDA) || (cmd == CMD_WRA);
   assign is_rw    = is_ap || (cmd == CMD_RD) || (cmd == CMD_WR);
   assign is_ref   = (cmd == CMD_REF);
   assign cur_act  = |(bank_active & sel);
   assign cur_pend = |(pend & sel);
   assign bad      = (is_act && cur_act) || (is_rw && (!cur_act || cur_pend))
                   || (is_ref && !all_idle);
   assign arm_val  = (ap_len == '0) ? '0 : ap_len - 1'b1;
   assign all_idle = ~|bank_active;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      assign sel[i]      = (ba == BA_W'(i));
      assign open_go[i]  = is_act && sel[i] && !bad;
      assign arm_go[i]   = is_ap && sel[i] && !bad;
      assign close_go[i] = (cmd == CMD_PREA) || ((cmd == CMD_PRE) && sel[i]);

      sdram_bank_slot #(.ROW_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
         .clk(clk), .rst_n(rst_n),
         .open_go(open_go[i]), .close_go(close_go[i]),
         .arm_go(arm_go[i]), .arm_val(arm_val), .row_in(addr),
         .active(bank_active[i]), .pending(pend[i]),
         .row(open_rows[i*ADDR_W +: ADDR_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_code <= 4'd0;
         cmd_bank <= '0;
         illegal  <= 1'b0;
      end else begin
         cmd_code <= cmd;
         cmd_bank <= ba;
         illegal  <= bad;
      end
   end

   // R1
   desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> cmd_code == 4'd0 && !illegal);
   // R9
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && pend == '0) |=> bank_active == $past(bank_active));
   // R7
   prea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PREA) |=> bank_active == '0);
   // R10
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_idle == (bank_active == '0));
endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic [3:0]  ap_len = 4'd4;
   logic [3:0]  cmd_code;
   logic [1:0]  cmd_bank;
   logic        illegal, all_idle;
   logic [3:0]  bank_active;
   logic [47:0] open_rows;

   int vectors = 0, errors = 0;
   bit m_act[4], m_pend[4];
   int m_row[4], m_cnt[4];
   int m_code = 0, m_ba = 0;
   bit m_ill = 0;

   always #2 clk = ~clk;

   sdram_cmd_tracker dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ap_len(ap_len),
      .cmd_code(cmd_code), .cmd_bank(cmd_bank), .illegal(illegal),
      .bank_active(bank_active), .open_rows(open_rows), .all_idle(all_idle)
   );

   function automatic int decode(bit c, bit r, bit a, bit w, bit k, bit f);
      if (c) return 0;
      case ({r, a, w})
         3'b111: return 1;
         3'b011: return 2;
         3'b101: return f ? 4 : 3;
         3'b100: return f ? 6 : 5;
         3'b010: return f ? 8 : 7;
         3'b001: return k ? 9 : 10;
         default: return 10;
      endcase
   endfunction

   task automatic model_step();
      int  code = decode(cs_n, ras_n, cas_n, we_n, cke, addr[10]);
      int  b = int'(ba);
      bit  any = 0, rw, bad;
      for (int i = 0; i < 4; i++) any |= m_act[i];
      rw  = (code >= 3 && code <= 6);
      bad = (code == 2 && m_act[b]) || (rw && (!m_act[b] || m_pend[b])) || (code == 9 && any);
      for (int i = 0; i < 4; i++) begin
         bit pre = (code == 8) || (code == 7 && i == b);
         if (pre) begin
            m_act[i] = 0; m_pend[i] = 0;
         end else if (m_pend[i]) begin
            if (m_cnt[i] == 0) begin m_act[i] = 0; m_pend[i] = 0; end
            else m_cnt[i]--;
         end
      end
      if (!bad && code == 2) begin m_act[b] = 1; m_row[b] = int'(addr); end
      if (!bad && (code == 4 || code == 6)) begin
         m_pend[b] = 1; m_cnt[b] = (ap_len == 0) ? 0 : int'(ap_len) - 1;
      end
      m_code = code; m_ba = b; m_ill = bad;
   endtask

   task automatic compare(string tag);
      logic [3:0] ea;
      vectors++;
      for (int i = 0; i < 4; i++) ea[i] = m_act[i];
      if (cmd_code !== 4'(m_code)) begin errors++;
         $display("FAIL %s cmd_code actual %0d expected %0d", tag, cmd_code, m_code); end
      if (cmd_bank !== 2'(m_ba)) begin errors++;
         $display("FAIL %s cmd_bank actual %0d expected %0d", tag, cmd_bank, m_ba); end
      if (illegal !== m_ill) begin errors++;
         $display("FAIL %s illegal actual %0b expected %0b", tag, illegal, m_ill); end
      if (bank_active !== ea) begin errors++;
         $display("FAIL %s bank_active actual %b expected %b", tag, bank_active, ea); end
      if (all_idle !== (ea == 0)) begin errors++;
         $display("FAIL R10 all_idle actual %0b expected %0b", all_idle, ea == 0); end
      for (int i = 0; i < 4; i++)
         if (open_rows[i*12 +: 12] !== 12'(m_row[i])) begin errors++;
            $display("FAIL %s row%0d actual %h expected %h", tag, i, open_rows[i*12 +: 12], m_row[i]); end
   endtask

   task automatic apply(string tag, bit c, bit r, bit a, bit w, int b, int ad, bit k = 1);
      @(negedge clk);
      cs_n = c; ras_n = r; cas_n = a; we_n = w; ba = 2'(b); addr = 12'(ad); cke = k;
      @(posedge clk);
      model_step();
      #1 compare(tag);
   endtask

   task automatic nop(string tag); apply(tag, 0, 1, 1, 1, 0, 0); endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_act[i] = 0; m_pend[i] = 0; m_row[i] = 0; m_cnt[i] = 0; end
      repeat (3) @(posedge clk);
      #1 compare("R11");
      rst_n = 1'b1;
      apply("R1", 1, 0, 1, 1, 1, 'h3AB);      // deselect with ACT strobes
      apply("R2", 0, 1, 1, 1, 2, 'h111);      // NOP
      apply("R3", 0, 0, 1, 1, 0, 'hABC);      // ACT bank0
      apply("R3", 0, 0, 1, 1, 2, 'h123);      // ACT bank2
      apply("R9", 0, 0, 1, 1, 0, 'h555);      // ACT to active bank
      apply("R4", 0, 1, 0, 1, 0, 'h0FF);      // RD bank0
      apply("R4", 0, 1, 0, 0, 2, 'h1FF);      // WR bank2
      apply("R9", 0, 1, 0, 1, 1, 'h010);      // RD idle bank1
      apply("R9", 0, 0, 0, 1, 0, 0);          // REF while active
      apply("R8", 0, 0, 0, 1, 0, 0, 0);       // refresh strobes, cke low
      apply("R2", 0, 0, 0, 0, 1, 0);          // other combination
      apply("R2", 0, 1, 1, 0, 3, 0);          // other combination
      apply("R6", 0, 0, 1, 0, 2, 0);          // PRE bank2
      apply("R6", 0, 0, 1, 0, 3, 0);          // PRE idle bank3
      ap_len = 4'd3;
      apply("R5", 0, 1, 0, 1, 0, 'h400);      // RDA bank0
      apply("R9", 0, 1, 0, 0, 0, 'h004);      // WR to closing bank
      repeat (3) nop("R5");
      apply("R3", 0, 0, 1, 1, 0, 'hFFF);
      ap_len = 4'd0;
      apply("R5", 0, 1, 0, 0, 0, 'h400);      // WRA with zero length
      nop("R5");
      ap_len = 4'd5;
      apply("R3", 0, 0, 1, 1, 1, 'h0F0);
      apply("R3", 0, 0, 1, 1, 3, 'h00F);
      apply("R5", 0, 1, 0, 0, 1, 'h400);      // WRA bank1
      nop("R5");
      apply("R6", 0, 0, 1, 0, 1, 0);          // PRE cancels pending
      repeat (6) nop("R6");
      apply("R3", 0, 0, 1, 1, 0, 'h777);
      apply("R7", 0, 0, 1, 0, 2, 'h400);      // PREA
      apply("R8", 0, 0, 0, 1, 0, 0);          // REF legal
      for (int n = 0; n < 3000; n++) begin
         int sel = $urandom_range(0, 9);
         ap_len = 4'($urandom_range(0, 6));
         case (sel)
            0:       apply("R1", 1, 1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3), $urandom);
            1, 2:    apply("R3", 0, 0, 1, 1, $urandom_range(0, 3), $urandom);
            3, 4:    apply("R4", 0, 1, 0, 1'($urandom), $urandom_range(0, 3), $urandom);
            5:       apply("R6", 0, 0, 1, 0, $urandom_range(0, 3), $urandom & 'hBFF);
            6:       apply("R7", 0, 0, 0 | 1'($urandom_range(0, 7) != 0), 1'($urandom), $urandom_range(0, 3), $urandom);
            7:       apply("R8", 0, 0, 0, 1, 0, 0, 1'($urandom));
            default: nop("R2");
         endcase
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule